// File: doc/BRIEF.md
# Four-Stage Pipeline Interlock and Bypass Controller

This block is the hazard controller for a small in-order pipeline with four one-cycle stages: fetch, decode, execute and write. Every cycle it compares the source registers of the instruction in decode with the destination registers of the instructions in execute and write. From that comparison it decides whether decode may advance, whether a bubble goes into execute, and which value each ALU input takes. It also discards the two wrong-path instructions when a branch that was assumed not taken resolves as taken. A toy datapath sits around the controller so that its decisions can be seen at the write-back port: a two-read one-write register file, an adder ALU, a late-result load and a branch-if-nonzero.

The fetch side is external. The instruction presented on `instr_i` is the instruction in fetch. It is captured into decode at a clock edge when `fetch_en_o` is high and `squash_o` is low. When `squash_o` is high, the supplier restarts at `redirect_tgt_o`. The `fwd_en` input selects between bypass mode and interlock-only mode. It is changed only while reset is asserted.

Top module: `pipe_hz_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `stall_o`, `squash_o` and `wb_valid_o` are 0 and `fetch_en_o` is 1.
- R2: The instruction word is `{imm[7:0], rs2[2:0], rs1[2:0], rd[2:0], op[1:0]}` with op 0=NOP, 1=ADD (rd = rs1+rs2+imm), 2=LOAD (rd = bitwise NOT of (rs1+imm)), 3=BNZ (go to absolute index imm if rs1 != 0). Write-backs appear on `wb_*` in program order with the values that sequential execution gives, in both modes.
- R3: In bypass mode, an ADD that reads the destination of the ADD directly ahead of it does not stall and retires one cycle after it. While it is in execute, its operand select reads 2'b01 (ALU result).
- R4: In interlock-only mode, an instruction reading the destination of the instruction directly ahead waits two stall cycles and retires three cycles after its producer.
- R5: In bypass mode, a consumer directly behind a LOAD stalls exactly one cycle and then takes the value from the write stage (select 2'b10). It retires two cycles after the LOAD.
- R6: With one independent instruction between producer and consumer, bypass mode needs no stall and uses select 2'b10. Interlock-only mode needs exactly one stall.
- R7: When both execute and write hold producers of the same register, the consumer gets the younger one's value.
- R8: Register 0 reads as zero, is never written back, and never causes a stall or a bypass.
- R9: A taken BNZ raises `squash_o` for one cycle with `redirect_tgt_o` = imm. The two wrong-path instructions never write back, and execution continues at the target.
- R10: A BNZ whose operand is zero raises no squash, and the fall-through instructions write back.
- R11: When a squash and a decode hazard occur in the same cycle, the squash wins: `stall_o` is 0 and `fetch_en_o` is 1.
- R12: While `stall_o` is 1, `fetch_en_o` is 0 and execute receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1 = bypass mode, 0 = interlock-only mode |
| instr_i | input | 19 | Instruction in the fetch stage |
| fetch_en_o | output | 1 | Fetch/decode advance enable |
| stall_o | output | 1 | Bubble inserted into execute this cycle |
| squash_o | output | 1 | Discard fetch and decode, redirect |
| redirect_tgt_o | output | 8 | Branch target index when squashing |
| sel_a_o | output | 2 | ALU input A select in execute (00 file, 01 ALU, 10 write stage) |
| sel_b_o | output | 2 | ALU input B select in execute |
| wb_valid_o | output | 1 | Register write this cycle |
| wb_rd_o | output | 3 | Register written |
| wb_data_o | output | 16 | Value written |

## Verification
The bench goes after dependency distances of one and two in both modes. A missing bypass shows up as a wrong written value. A bypass that skips its interlock shows up as the wrong stall count and a stretched retire gap. A consumer behind a LOAD is checked for its single stall, because bypassing without that stall would add a stale address instead of the loaded data. A double write to one register followed by a read exposes a priority that favours the older producer. Taken branches, including one that coincides with a decode interlock, show whether wrong-path instructions leak into write-back or the stall wins over the squash and freezes the wrong instruction in decode. Writes to register 0 check that they neither retire nor interlock.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ADD  = 2'd1,
    OP_LOAD = 2'd2,
    OP_BNZ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_ALU = 2'd1,
    SEL_WB  = 2'd2
  } opsel_e;

  function automatic logic op_writes(input op_e op);
    return (op == OP_ADD) || (op == OP_LOAD);
  endfunction
endpackage

// File: rtl/pipe_hz_regfile.sv
module pipe_hz_regfile #(
  parameter int RA_W   = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   ra_a,
  input  logic [RA_W-1:0]   ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [RA_W-1:0]   wa,
  input  logic [DATA_W-1:0] wd
);
  localparam int REG_N = 1 << RA_W;
  logic [DATA_W-1:0] regs_q [REG_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
endmodule

// File: rtl/pipe_hz_ctrl.sv
module pipe_hz_ctrl
  import pipe_hz_pkg::*;
#(
  parameter int RA_W = 3
) (
  input  logic            fwd_en,
  input  logic            d_valid,
  input  op_e             d_op,
  input  logic [RA_W-1:0] d_rs1,
  input  logic [RA_W-1:0] d_rs2,
  input  logic            e_valid,
  input  op_e             e_op,
  input  logic [RA_W-1:0] e_rd,
  input  logic            w_valid,
  input  op_e             w_op,
  input  logic [RA_W-1:0] w_rd,
  input  logic            e_taken,
  output logic            stall,
  output logic            squash,
  output opsel_e          sel_a,
  output opsel_e          sel_b
);
  logic use_a, use_b, e_prod, w_prod;
  logic ma_e, mb_e, ma_w, mb_w, hazard;

  always_comb begin
    use_a  = d_valid && (d_op != OP_NOP) && (d_rs1 != '0);
    use_b  = d_valid && (d_op == OP_ADD) && (d_rs2 != '0);
    e_prod = e_valid && op_writes(e_op) && (e_rd != '0);
    w_prod = w_valid && op_writes(w_op) && (w_rd != '0);
    ma_e   = use_a && e_prod && (e_rd == d_rs1);
    mb_e   = use_b && e_prod && (e_rd == d_rs2);
    ma_w   = use_a && w_prod && (w_rd == d_rs1);
    mb_w   = use_b && w_prod && (w_rd == d_rs2);
    if (fwd_en) hazard = (ma_e || mb_e) && (e_op == OP_LOAD);
    else        hazard = ma_e || mb_e || ma_w || mb_w;
    squash = e_taken;
    stall  = hazard && !e_taken;
    // youngest producer (execute) is checked first
    if (fwd_en && ma_e)      sel_a = SEL_ALU;
    else if (fwd_en && ma_w) sel_a = SEL_WB;
    else                     sel_a = SEL_RF;
    if (fwd_en && mb_e)      sel_b = SEL_ALU;
    else if (fwd_en && mb_w) sel_b = SEL_WB;
    else                     sel_b = SEL_RF;
  end
endmodule

// File: rtl/pipe_hz_top.sv
module pipe_hz_top
  import pipe_hz_pkg::*;
#(
  parameter int RA_W   = 3,
  parameter int IMM_W  = 8,
  parameter int DATA_W = 16,
  localparam int IW    = 2 + 3 * RA_W + IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_en,
  input  logic [IW-1:0]     instr_i,
  output logic              fetch_en_o,
  output logic              stall_o,
  output logic              squash_o,
  output logic [IMM_W-1:0]  redirect_tgt_o,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic              wb_valid_o,
  output logic [RA_W-1:0]   wb_rd_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int RD_LSB  = 2;
  localparam int RS1_LSB = RD_LSB + RA_W;
  localparam int RS2_LSB = RS1_LSB + RA_W;
  localparam int IMM_LSB = RS2_LSB + RA_W;

  typedef struct packed {
    logic             valid;
    op_e              op;
    logic [RA_W-1:0]  rd;
    logic [IMM_W-1:0] imm;
    opsel_e           sel_a;
    opsel_e           sel_b;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
  } ex_t;

  typedef struct packed {
    logic              valid;
    op_e               op;
    logic [RA_W-1:0]   rd;
    logic [DATA_W-1:0] res;
  } wr_t;

  logic          d_valid_q, d_valid_n;
  logic [IW-1:0] d_ins_q, d_ins_n;
  ex_t           e_q, e_n;
  wr_t           w_q, w_n;

  op_e              d_op;
  logic [RA_W-1:0]  d_rd, d_rs1, d_rs2;
  logic [IMM_W-1:0] d_imm;
  logic [DATA_W-1:0] rf_a, rf_b, a_val, b_val, imm_ext, alu_res, w_data;
  logic   e_taken, stall, squash, w_we;
  opsel_e sel_a, sel_b;

  assign d_op  = op_e'(d_ins_q[1:0]);
  assign d_rd  = d_ins_q[RD_LSB +: RA_W];
  assign d_rs1 = d_ins_q[RS1_LSB +: RA_W];
  assign d_rs2 = d_ins_q[RS2_LSB +: RA_W];
  assign d_imm = d_ins_q[IMM_LSB +: IMM_W];

  pipe_hz_regfile #(.RA_W(RA_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra_a(d_rs1), .ra_b(d_rs2),
    .rd_a(rf_a), .rd_b(rf_b), .we(w_we), .wa(w_q.rd), .wd(w_data)
  );

  pipe_hz_ctrl #(.RA_W(RA_W)) u_ctrl (
    .fwd_en(fwd_en), .d_valid(d_valid_q), .d_op(d_op), .d_rs1(d_rs1), .d_rs2(d_rs2),
    .e_valid(e_q.valid), .e_op(e_q.op), .e_rd(e_q.rd),
    .w_valid(w_q.valid), .w_op(w_q.op), .w_rd(w_q.rd),
    .e_taken(e_taken), .stall(stall), .squash(squash), .sel_a(sel_a), .sel_b(sel_b)
  );

  // execute stage: operand muxes and adder
  always_comb begin
    a_val   = (e_q.sel_a == SEL_ALU) ? w_q.res : e_q.opa;
    b_val   = (e_q.sel_b == SEL_ALU) ? w_q.res : e_q.opb;
    imm_ext = {{(DATA_W-IMM_W){1'b0}}, e_q.imm};
    case (e_q.op)
      OP_ADD:  alu_res = a_val + b_val + imm_ext;
      OP_LOAD: alu_res = a_val + imm_ext;
      default: alu_res = '0;
    endcase
    e_taken = e_q.valid && (e_q.op == OP_BNZ) && (a_val != '0);
  end

  // write stage: late load data and register write
  assign w_data = (w_q.op == OP_LOAD) ? ~w_q.res : w_q.res;
  assign w_we   = w_q.valid && op_writes(w_q.op) && (w_q.rd != '0);

  always_comb begin
    d_valid_n = d_valid_q;
    d_ins_n   = d_ins_q;
    e_n       = '0;
    w_n.valid = e_q.valid;
    w_n.op    = e_q.op;
    w_n.rd    = e_q.rd;
    w_n.res   = alu_res;
    if (squash) begin
      d_valid_n = 1'b0;
    end else if (!stall) begin
      d_valid_n = 1'b1;
      d_ins_n   = instr_i;
      e_n.valid = d_valid_q;
      e_n.op    = d_op;
      e_n.rd    = d_rd;
      e_n.imm   = d_imm;
      e_n.sel_a = (sel_a == SEL_ALU) ? SEL_ALU : SEL_RF;
      e_n.sel_b = (sel_b == SEL_ALU) ? SEL_ALU : SEL_RF;
      e_n.opa   = (sel_a == SEL_WB) ? w_data : rf_a;
      e_n.opb   = (sel_b == SEL_WB) ? w_data : rf_b;
      if (sel_a == SEL_WB) e_n.sel_a = SEL_WB;
      if (sel_b == SEL_WB) e_n.sel_b = SEL_WB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid_q <= 1'b0;
      d_ins_q   <= '0;
      e_q       <= '0;
      w_q       <= '0;
    end else begin
      d_valid_q <= d_valid_n;
      d_ins_q   <= d_ins_n;
      e_q       <= e_n;
      w_q       <= w_n;
    end
  end

  assign fetch_en_o     = !stall;
  assign stall_o        = stall;
  assign squash_o       = squash;
  assign redirect_tgt_o = e_q.imm;
  assign sel_a_o        = e_q.sel_a;
  assign sel_b_o        = e_q.sel_b;
  assign wb_valid_o     = w_we;
  assign wb_rd_o        = w_q.rd;
  assign wb_data_o      = w_data;
endmodule

// File: rtl/pipe_hz_chk.sv
module pipe_hz_chk #(
  parameter int RA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_en_o,
  input logic            stall_o,
  input logic            squash_o,
  input logic [1:0]      sel_a_o,
  input logic [1:0]      sel_b_o,
  input logic            wb_valid_o,
  input logic [RA_W-1:0] wb_rd_o
);
  a_r12_stall_freezes_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !fetch_en_o);
  a_r12_bubble_not_branch: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !squash_o);
  a_r11_squash_beats_stall: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |-> (fetch_en_o && !stall_o));
  a_r9_squash_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    squash_o |=> !squash_o);
  a_r8_no_r0_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> (wb_rd_o != '0));
  a_r3_alu_fwd_has_producer_a: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_o == 2'b01) |-> wb_valid_o);
  a_r3_alu_fwd_has_producer_b: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b_o == 2'b01) |-> wb_valid_o);
endmodule

bind pipe_hz_top pipe_hz_chk #(.RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_en_o(fetch_en_o), .stall_o(stall_o),
  .squash_o(squash_o), .sel_a_o(sel_a_o), .sel_b_o(sel_b_o),
  .wb_valid_o(wb_valid_o), .wb_rd_o(wb_rd_o)
);

// File: tb/pipe_hz_tb.sv
module pipe_hz_top_tb_top;
  localparam int IW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_en = 1'b0;
  logic [IW-1:0] instr = '0;
  logic fetch_en, stall, squash, wb_valid;
  logic [7:0] tgt;
  logic [1:0] sel_a, sel_b;
  logic [2:0] wb_rd;
  logic [15:0] wb_data;

  int checks = 0;
  int fails = 0;
  int wd_cnt = 0;

  always #10 clk = ~clk;

  pipe_hz_top dut_i (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .instr_i(instr),
    .fetch_en_o(fetch_en), .stall_o(stall), .squash_o(squash), .redirect_tgt_o(tgt),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .wb_valid_o(wb_valid), .wb_rd_o(wb_rd), .wb_data_o(wb_data)
  );

  logic [IW-1:0] prog [0:15];
  int plen;
  logic [2:0]  exp_rd [0:31];
  logic [15:0] exp_d  [0:31];
  int n_exp;
  int rc [0:31];
  int n_ret, n_stall, n_squash, n_alu_a, n_wb_a, n_alu_b;

  function automatic logic [IW-1:0] mk(input int op, input int rd, input int rs1,
                                       input int rs2, input int imm);
    return {imm[7:0], rs2[2:0], rs1[2:0], rd[2:0], op[1:0]};
  endfunction

  task automatic chk(input string req, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // sequential architectural model
  task automatic model();
    logic [15:0] r [0:7];
    int pc = 0;
    int steps = 0;
    for (int i = 0; i < 8; i++) r[i] = '0;
    n_exp = 0;
    while (pc < plen && steps < 64) begin
      logic [IW-1:0] w = prog[pc];
      int op = int'(w[1:0]);
      int rd = int'(w[4:2]);
      int s1 = int'(w[7:5]);
      int s2 = int'(w[10:8]);
      logic [15:0] im = {8'h00, w[18:11]};
      logic [15:0] v = '0;
      steps++;
      pc++;
      if (op == 3) begin
        if (r[s1] != 0) pc = int'(im);
      end else if (op != 0) begin
        v = (op == 1) ? r[s1] + r[s2] + im : ~(r[s1] + im);
        if (rd != 0) begin
          r[rd] = v;
          exp_rd[n_exp] = rd[2:0];
          exp_d[n_exp] = v;
          n_exp++;
        end
      end
    end
  endtask

  task automatic run(input string req, input logic fwd);
    int pc = 0;
    int pc_n;
    model();
    n_ret = 0; n_stall = 0; n_squash = 0; n_alu_a = 0; n_wb_a = 0; n_alu_b = 0;
    rst_n = 1'b0;
    fwd_en = fwd;
    instr = prog[0];
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", !stall && !squash && fetch_en && !wb_valid,
        int'({stall, squash, fetch_en, wb_valid}), 2);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (wb_valid) begin
        if (n_ret < n_exp)
          chk({req, " R2 writeback"}, wb_rd == exp_rd[n_ret] && wb_data == exp_d[n_ret],
              int'(wb_data), int'(exp_d[n_ret]));
        else
          chk({req, " R2 unexpected writeback"}, 1'b0, int'(wb_rd), -1);
        if (n_ret < 32) rc[n_ret] = cyc;
        n_ret++;
      end
      if (stall) n_stall++;
      if (squash) n_squash++;
      if (sel_a == 2'b01) n_alu_a++;
      if (sel_a == 2'b10) n_wb_a++;
      if (sel_b == 2'b01) n_alu_b++;
      if (squash) pc_n = int'(tgt);
      else if (fetch_en) pc_n = pc + 1;
      else pc_n = pc;
      @(posedge clk); #1;
      pc = pc_n;
      instr = (pc < plen) ? prog[pc] : '0;
    end
    chk({req, " R2 writeback count"}, n_ret == n_exp, n_ret, n_exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd_cnt, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // back-to-back dependency
    plen = 2;
    prog[0] = mk(1, 1, 0, 0, 5);
    prog[1] = mk(1, 2, 1, 1, 1);
    run("R3 fwd", 1'b1);
    chk("R3 no stall", n_stall == 0, n_stall, 0);
    chk("R3 retire gap", rc[1] - rc[0] == 1, rc[1] - rc[0], 1);
    chk("R3 alu select both", n_alu_a == 1 && n_alu_b == 1, n_alu_a + n_alu_b, 2);
    run("R4 nofwd", 1'b0);
    chk("R4 two stalls", n_stall == 2, n_stall, 2);
    chk("R4 retire gap", rc[1] - rc[0] == 3, rc[1] - rc[0], 3);
    chk("R4 no bypass select", n_alu_a == 0 && n_wb_a == 0, n_alu_a + n_wb_a, 0);

    // load-use
    prog[0] = mk(2, 1, 0, 0, 8);
    prog[1] = mk(1, 2, 1, 0, 1);
    run("R5 fwd", 1'b1);
    chk("R5 one stall", n_stall == 1, n_stall, 1);
    chk("R5 retire gap", rc[1] - rc[0] == 2, rc[1] - rc[0], 2);
    chk("R5 write-stage select", n_wb_a == 1 && n_alu_a == 0, n_wb_a, 1);

    // distance two
    plen = 3;
    prog[0] = mk(1, 1, 0, 0, 3);
    prog[1] = mk(1, 4, 0, 0, 4);
    prog[2] = mk(1, 3, 1, 0, 2);
    run("R6 fwd", 1'b1);
    chk("R6 fwd no stall", n_stall == 0, n_stall, 0);
    chk("R6 fwd write-stage select", n_wb_a == 1, n_wb_a, 1);
    run("R6 nofwd", 1'b0);
    chk("R6 nofwd one stall", n_stall == 1, n_stall, 1);

    // youngest producer
    prog[0] = mk(1, 1, 0, 0, 1);
    prog[1] = mk(1, 1, 0, 0, 2);
    prog[2] = mk(1, 2, 1, 0, 0);
    run("R7 fwd", 1'b1);
    run("R7 nofwd", 1'b0);

    // register zero
    plen = 2;
    prog[0] = mk(1, 0, 0, 0, 9);
    prog[1] = mk(1, 1, 0, 0, 1);
    run("R8 nofwd", 1'b0);
    chk("R8 no stall on r0", n_stall == 0, n_stall, 0);
    run("R8 fwd", 1'b1);
    chk("R8 no bypass on r0", n_alu_a == 0 && n_wb_a == 0, n_alu_a + n_wb_a, 0);

    // taken branch
    plen = 6;
    prog[0] = mk(1, 1, 0, 0, 1);
    prog[1] = mk(3, 0, 1, 0, 5);
    prog[2] = mk(1, 2, 0, 0, 7);
    prog[3] = mk(1, 3, 0, 0, 7);
    prog[4] = mk(1, 4, 0, 0, 7);
    prog[5] = mk(1, 5, 1, 0, 10);
    run("R9 fwd", 1'b1);
    chk("R9 one squash", n_squash == 1, n_squash, 1);
    run("R9 nofwd", 1'b0);
    chk("R9 nofwd one squash", n_squash == 1, n_squash, 1);

    // not-taken branch
    prog[0] = mk(1, 1, 0, 0, 0);
    run("R10 fwd", 1'b1);
    chk("R10 no squash", n_squash == 0, n_squash, 0);

    // squash together with decode hazard
    plen = 9;
    prog[0] = mk(1, 7, 0, 0, 1);
    prog[1] = mk(0, 0, 0, 0, 0);
    prog[2] = mk(0, 0, 0, 0, 0);
    prog[3] = mk(1, 1, 0, 0, 4);
    prog[4] = mk(3, 0, 7, 0, 8);
    prog[5] = mk(1, 2, 1, 0, 0);
    prog[6] = mk(1, 6, 0, 0, 6);
    prog[7] = mk(1, 6, 0, 0, 6);
    prog[8] = mk(1, 3, 1, 0, 1);
    run("R11 nofwd", 1'b0);
    chk("R11 squash taken", n_squash == 1, n_squash, 1);
    chk("R11 stall suppressed at squash", n_stall == 0, n_stall, 0);

    // stall freezes fetch (R12)
    plen = 2;
    prog[0] = mk(1, 1, 0, 0, 5);
    prog[1] = mk(1, 2, 1, 0, 0);
    run("R12 nofwd", 1'b0);
    chk("R12 stall cycles seen", n_stall == 2, n_stall, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule